// File: doc/BRIEF.md
# Multi-Parameter Linear Sweep Sequencer

This block ramps a set of waveform parameters (frequency word, amplitude, offset and phase by default; `NPAR` lanes of `W` bits) in straight lines between two programmed bounds. It runs all lanes together. The host supplies, for every lane, a lower bound, an upper bound, and a signed increment for each direction. It also supplies a step count for the rising leg, a step count for the falling leg, and a step interval. Starting, stopping and the choice of pattern are set through a one-cycle command strobe. The live lane values go straight to the synthesis core and the output scaling stage.

Steps fall on a timing grid of `GRID_DIV` clocks per grid tick. A step is taken every `interval` grid ticks. Within a leg, each step adds the leg's increment to the lane. The last step of a leg loads the bound exactly, so rounding error from the increments never builds up. A lane whose two bounds are both zero takes no part and keeps its value.

The controller has five states. `ST_IDLE` is the rest state after reset or a halt. `ST_LEG_A` is the first leg of a pattern. `ST_LEG_B` is the return leg of a two-leg pattern. `ST_REARM` is the one-step jump back to the start bound in a continuous single-leg pattern. `ST_HELD` is the hold state at the end of a single-shot pattern. The transitions are as follows. *start* goes from any state to `ST_LEG_A`. *halt* goes from any state to `ST_IDLE`. *turn* goes from `ST_LEG_A` to `ST_LEG_B`. *rearm* goes from `ST_LEG_A` to `ST_REARM`. *resume* goes from `ST_REARM` or `ST_LEG_B` to `ST_LEG_A`. *finish* goes from `ST_LEG_A` or `ST_LEG_B` to `ST_HELD`.

Top module: `param_sweep_seq`

## Requirements
- R1: Command codes are 1 = rise (lower to upper), 2 = fall (upper to lower), 3 = rise then fall, 4 = fall then rise, and 0 = halt. On the clock edge that samples a start code (1 to 4), every enabled lane loads its start bound: lower for codes 1 and 3, upper for codes 2 and 4. On the same edge `busy` goes to 1 and `done` goes to 0.
- R2: With `GRID_DIV` = 1, step k of a run takes effect on the clock edge k·max(interval,1) after the start edge. An interval of 0 behaves like 1.
- R3: On a rising leg of N steps, where N = max(steps_up,1), a lane holds lower + k·inc_up after step k for k < N, and exactly upper after step N. A falling leg behaves the same way with N = max(steps_dn,1), upper + k·inc_dn, and lower at the end. All sums wrap modulo 2^W.
- R4: In codes 3 and 4, the second leg starts on the step after the first leg's final step. It runs in the opposite direction and uses that direction's step count.
- R5: In single-shot mode (`cont_mode` = 0 when the start is sampled), once the pattern's final step has taken effect the lanes hold, `busy` = 0 and `done` = 1.
- R6: In continuous mode, a single-leg pattern jumps back to its start bound one step after its final step and then repeats. A two-leg pattern goes straight into its first leg again. `busy` stays 1.
- R7: A lane whose lower and upper bounds are both zero keeps its current value through starts and steps.
- R8: Code 0 freezes all lanes at their current values. On the next edge it clears both `busy` and `done`, and no later step changes a lane.
- R9: A start code sampled while busy restarts the new pattern from its start bound. Step timing is counted from the restart edge.
- R10: Codes 5 to 7 are ignored: the pattern, its step timing and the lane values carry on as if no command were given.
- R11: After reset every lane is 0, `busy` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Command code (see R1, R10) |
| cont_mode | input | 1 | 1 = continuous repetition, sampled at start |
| steps_up | input | SW | Steps on a rising leg (0 acts as 1) |
| steps_dn | input | SW | Steps on a falling leg (0 acts as 1) |
| interval | input | IW | Grid ticks between steps (0 acts as 1) |
| lo_bus | input | NPAR·W | Lower bounds, lane i at bits [i·W +: W] |
| hi_bus | input | NPAR·W | Upper bounds, same packing |
| inc_up_bus | input | NPAR·W | Signed per-step increments for rising legs |
| inc_dn_bus | input | NPAR·W | Signed per-step increments for falling legs |
| value_bus | output | NPAR·W | Live lane values |
| busy | output | 1 | A pattern is in progress |
| done | output | 1 | A single-shot pattern has finished and is holding |

## Verification
The assertions assume that bounds, increments, step counts and the interval stay constant while a pattern runs. The step-count range check and the frozen-lane check depend on this. The assertions also assume that `cmd_valid` is a single-cycle pulse. The stimulus changes configuration only while the block is idle or holding, or on the same cycle as a new start. One restart case and one reserved-code case are issued in mid-pattern. All other changes come after a halt, so every check is made against steady inputs.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [2:0] {
        CMD_HALT      = 3'd0,
        CMD_RISE      = 3'd1,
        CMD_FALL      = 3'd2,
        CMD_RISE_FALL = 3'd3,
        CMD_FALL_RISE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEG_A,
        ST_LEG_B,
        ST_REARM,
        ST_HELD
    } state_e;

    typedef enum logic [2:0] {
        ACT_KEEP,
        ACT_SET_LO,
        ACT_SET_HI,
        ACT_ADD_UP,
        ACT_ADD_DN
    } act_e;

endpackage

// File: rtl/sweep_pacer.sv
module sweep_pacer #(
    parameter int GRID_DIV = 1,
    parameter int IW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [IW-1:0] interval,
    output logic          step
);

    logic          grid;
    logic [IW-1:0] iv_eff;
    logic [IW-1:0] tick_cnt;

    generate
        if (GRID_DIV <= 1) begin : g_no_div
            assign grid = 1'b1;
        end else begin : g_div
            localparam int GW = $clog2(GRID_DIV);
            logic [GW-1:0] gcnt;
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    gcnt <= '0;
                end else if (gcnt == GW'(GRID_DIV - 1)) begin
                    gcnt <= '0;
                end else begin
                    gcnt <= gcnt + 1'b1;
                end
            end
            assign grid = (gcnt == GW'(GRID_DIV - 1));
        end
    endgenerate

    always_comb begin
        iv_eff = (interval == '0) ? IW'(1) : interval;
    end

    assign step = run && grid && (tick_cnt == iv_eff - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (restart || !run || step) begin
            tick_cnt <= '0;
        end else if (grid) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && iv_eff > IW'(1)) |=> !step); // R2

endmodule

// File: rtl/sweep_lane.sv
module sweep_lane
    import sweep_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  act_e         act,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] inc_up,
    input  logic [W-1:0] inc_dn,
    output logic [W-1:0] value
);

    logic enabled;

    assign enabled = (lo != '0) || (hi != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (enabled) begin
            unique case (act)
                ACT_SET_LO: value <= lo;
                ACT_SET_HI: value <= hi;
                ACT_ADD_UP: value <= value + inc_up;
                ACT_ADD_DN: value <= value + inc_dn;
                default:    value <= value;
            endcase
        end
    end

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> $stable(value)); // R7

    AST_TOP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && act == ACT_SET_HI) |=> value == $past(hi)); // R3

    AST_BOTTOM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && act == ACT_SET_LO) |=> value == $past(lo)); // R3

endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
    import sweep_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic          cont_mode,
    input  logic [SW-1:0] steps_up,
    input  logic [SW-1:0] steps_dn,
    input  logic          step,
    output act_e          act,
    output logic          busy,
    output logic          done,
    output logic          restart
);

    state_e        state, state_n;
    logic [SW-1:0] step_cnt, step_cnt_n;
    logic          first_up, two_leg, cont_r;
    logic          is_start, is_halt, new_up;
    logic          leg_up, last;
    logic [SW-1:0] leg_len;

    assign is_halt  = cmd_valid && (cmd_code == CMD_HALT);
    assign is_start = cmd_valid && (cmd_code >= CMD_RISE) && (cmd_code <= CMD_FALL_RISE);
    assign new_up   = (cmd_code == CMD_RISE) || (cmd_code == CMD_RISE_FALL);

    always_comb begin
        leg_up  = (state == ST_LEG_B) ? !first_up : first_up;
        leg_len = leg_up ? ((steps_up == '0) ? SW'(1) : steps_up)
                         : ((steps_dn == '0) ? SW'(1) : steps_dn);
        last    = (step_cnt == leg_len - 1'b1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
            first_up <= 1'b1;
            two_leg  <= 1'b0;
            cont_r   <= 1'b0;
        end else begin
            state    <= state_n;
            step_cnt <= step_cnt_n;
            if (is_start && !is_halt) begin
                first_up <= new_up;
                two_leg  <= (cmd_code == CMD_RISE_FALL) || (cmd_code == CMD_FALL_RISE);
                cont_r   <= cont_mode;
            end
        end
    end

    // Next state
    always_comb begin
        state_n    = state;
        step_cnt_n = step_cnt;
        if (is_halt) begin
            state_n    = ST_IDLE;
            step_cnt_n = '0;
        end else if (is_start) begin
            state_n    = ST_LEG_A;
            step_cnt_n = '0;
        end else begin
            unique case (state)
                ST_LEG_A: begin
                    if (step) begin
                        if (last) begin
                            step_cnt_n = '0;
                            if (two_leg)     state_n = ST_LEG_B;
                            else if (cont_r) state_n = ST_REARM;
                            else             state_n = ST_HELD;
                        end else begin
                            step_cnt_n = step_cnt + 1'b1;
                        end
                    end
                end
                ST_LEG_B: begin
                    if (step) begin
                        if (last) begin
                            step_cnt_n = '0;
                            state_n    = cont_r ? ST_LEG_A : ST_HELD;
                        end else begin
                            step_cnt_n = step_cnt + 1'b1;
                        end
                    end
                end
                ST_REARM: begin
                    if (step) begin
                        state_n    = ST_LEG_A;
                        step_cnt_n = '0;
                    end
                end
                ST_IDLE, ST_HELD: begin
                    state_n = state;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        act     = ACT_KEEP;
        busy    = (state == ST_LEG_A) || (state == ST_LEG_B) || (state == ST_REARM);
        done    = (state == ST_HELD);
        restart = is_start && !is_halt;
        if (is_halt) begin
            act = ACT_KEEP;
        end else if (is_start) begin
            act = new_up ? ACT_SET_LO : ACT_SET_HI;
        end else if (step) begin
            unique case (state)
                ST_LEG_A, ST_LEG_B: begin
                    if (last) act = leg_up ? ACT_SET_HI : ACT_SET_LO;
                    else      act = leg_up ? ACT_ADD_UP : ACT_ADD_DN;
                end
                ST_REARM: act = first_up ? ACT_SET_LO : ACT_SET_HI;
                default:  act = ACT_KEEP;
            endcase
        end
    end

    AST_HALT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        is_halt |=> (!busy && !done)); // R8

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        is_start |=> (busy && !done)); // R1

    AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code > 3'd4 && !step) |=> (state == $past(state))); // R10

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEG_A || state == ST_LEG_B) |-> (step_cnt < leg_len)); // R3

    AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !cmd_valid) |=> (state == ST_HELD)); // R5

endmodule

// File: rtl/param_sweep_seq.sv
module param_sweep_seq
    import sweep_pkg::*;
#(
    parameter int NPAR     = 4,
    parameter int W        = 16,
    parameter int SW       = 8,
    parameter int IW       = 16,
    parameter int GRID_DIV = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_code,
    input  logic               cont_mode,
    input  logic [SW-1:0]      steps_up,
    input  logic [SW-1:0]      steps_dn,
    input  logic [IW-1:0]      interval,
    input  logic [NPAR*W-1:0]  lo_bus,
    input  logic [NPAR*W-1:0]  hi_bus,
    input  logic [NPAR*W-1:0]  inc_up_bus,
    input  logic [NPAR*W-1:0]  inc_dn_bus,
    output logic [NPAR*W-1:0]  value_bus,
    output logic               busy,
    output logic               done
);

    act_e act;
    logic step;
    logic restart;

    sweep_fsm #(.SW(SW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cont_mode (cont_mode),
        .steps_up  (steps_up),
        .steps_dn  (steps_dn),
        .step      (step),
        .act       (act),
        .busy      (busy),
        .done      (done),
        .restart   (restart)
    );

    sweep_pacer #(.GRID_DIV(GRID_DIV), .IW(IW)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .restart  (restart),
        .interval (interval),
        .step     (step)
    );

    generate
        for (genvar g = 0; g < NPAR; g++) begin : g_lane
            sweep_lane #(.W(W)) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .act    (act),
                .lo     (lo_bus[g*W +: W]),
                .hi     (hi_bus[g*W +: W]),
                .inc_up (inc_up_bus[g*W +: W]),
                .inc_dn (inc_dn_bus[g*W +: W]),
                .value  (value_bus[g*W +: W])
            );
        end
    endgenerate

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R5

endmodule

// File: tb/test_param_sweep_seq.sv
module test_param_sweep_seq;
    localparam int NP = 4;
    localparam int W  = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          cmd_valid;
    logic [2:0]    cmd_code;
    logic          cont_mode;
    logic [7:0]    steps_up, steps_dn;
    logic [15:0]   interval;
    logic [NP*W-1:0] lo_bus, hi_bus, inc_up_bus, inc_dn_bus, value_bus;
    logic          busy, done;

    param_sweep_seq #(.NPAR(NP), .W(W), .SW(8), .IW(16), .GRID_DIV(1)) i_param_sweep_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cont_mode(cont_mode), .steps_up(steps_up), .steps_dn(steps_dn),
        .interval(interval), .lo_bus(lo_bus), .hi_bus(hi_bus),
        .inc_up_bus(inc_up_bus), .inc_dn_bus(inc_dn_bus),
        .value_bus(value_bus), .busy(busy), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] lo_a [NP];
    logic [15:0] hi_a [NP];
    logic [15:0] iu_a [NP];
    logic [15:0] id_a [NP];
    logic [15:0] prev_v [NP];

    bit pat_up, pat_two, pat_cont;
    int iv, nu, nd;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            lo_bus[i*W +: W]     = lo_a[i];
            hi_bus[i*W +: W]     = hi_a[i];
            inc_up_bus[i*W +: W] = iu_a[i];
            inc_dn_bus[i*W +: W] = id_a[i];
        end
    end

    function automatic bit lane_on(int i);
        return (lo_a[i] != 16'd0) || (hi_a[i] != 16'd0);
    endfunction

    function automatic logic [15:0] leg_val(int i, bit up, int k, int len);
        logic [15:0] kk;
        kk = 16'(k);
        if (up) return (k >= len) ? hi_a[i] : lo_a[i] + kk * iu_a[i];
        return (k >= len) ? lo_a[i] : hi_a[i] + kk * id_a[i];
    endfunction

    function automatic int total_steps();
        return pat_two ? (nu + nd) : (pat_up ? nu : nd);
    endfunction

    function automatic logic [15:0] model(int i, int s);
        int l1, l2, p;
        l1 = pat_up ? nu : nd;
        l2 = pat_up ? nd : nu;
        if (!lane_on(i)) return prev_v[i];
        if (!pat_two) begin
            p = pat_cont ? (s % (l1 + 1)) : ((s > l1) ? l1 : s);
            return leg_val(i, pat_up, p, l1);
        end
        p = pat_cont ? (s % (l1 + l2)) : ((s > l1 + l2) ? (l1 + l2) : s);
        if (p <= l1) return leg_val(i, pat_up, p, l1);
        return leg_val(i, !pat_up, p - l1, l2);
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic set_pattern(int code, bit c, int ivr, int nur, int ndr);
        pat_up   = (code == 1) || (code == 3);
        pat_two  = (code == 3) || (code == 4);
        pat_cont = c;
        iv = (ivr == 0) ? 1 : ivr;
        nu = (nur == 0) ? 1 : nur;
        nd = (ndr == 0) ? 1 : ndr;
        interval  = 16'(ivr);
        steps_up  = 8'(nur);
        steps_dn  = 8'(ndr);
        cont_mode = c;
    endtask

    task automatic issue(int code);
        cmd_code  = 3'(code);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic check_at(int t, string force_tag);
        int s;
        string tag;
        bit eb, ed;
        s = t / iv;
        if (force_tag != "")  tag = force_tag;
        else if (t == 0)      tag = "R1";
        else if (iv > 1)      tag = "R2";
        else if (pat_cont)    tag = "R6";
        else if (pat_two)     tag = "R4";
        else                  tag = "R3";
        for (int i = 0; i < NP; i++)
            chk(lane_on(i) ? tag : "R7", int'(value_bus[i*W +: W]), int'(model(i, s)), $sformatf("lane%0d", i));
        eb = pat_cont ? 1'b1 : (s < total_steps());
        ed = !pat_cont && (s >= total_steps());
        chk(pat_cont ? "R6" : "R5", int'(busy), int'(eb), "busy");
        chk(pat_cont ? "R6" : "R5", int'(done), int'(ed), "done");
    endtask

    task automatic halt_check(int t);
        logic [15:0] frz [NP];
        for (int i = 0; i < NP; i++) frz[i] = model(i, t / iv);
        issue(0);
        for (int c = 0; c < 3; c++) begin
            chk("R8", int'(busy), 0, "busy after halt");
            chk("R8", int'(done), 0, "done after halt");
            for (int i = 0; i < NP; i++)
                chk("R8", int'(value_bus[i*W +: W]), int'(frz[i]), $sformatf("frozen lane%0d", i));
            @(negedge clk);
        end
        for (int i = 0; i < NP; i++) prev_v[i] = frz[i];
    endtask

    task automatic run_pattern(int code, bit c, int ivr, int nur, int ndr);
        int tl;
        set_pattern(code, c, ivr, nur, ndr);
        if (c) tl = 2 * (pat_two ? total_steps() : total_steps() + 1) * iv + iv;
        else   tl = total_steps() * iv + 2;
        issue(code);
        for (int t = 0; t <= tl; t++) begin
            if (t > 0) @(negedge clk);
            check_at(t, "");
        end
        halt_check(tl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 3'd0; cont_mode = 1'b0;
        steps_up = 8'd1; steps_dn = 8'd1; interval = 16'd1;
        lo_a[0] = 16'd100;   hi_a[0] = 16'd407;   iu_a[0] = 16'd100;   id_a[0] = 16'hFF9C;
        lo_a[1] = 16'd1000;  hi_a[1] = 16'd1990;  iu_a[1] = 16'd333;   id_a[1] = 16'hFEB3;
        lo_a[2] = 16'd50;    hi_a[2] = 16'd80;    iu_a[2] = 16'd10;    id_a[2] = 16'hFFF6;
        lo_a[3] = 16'hFF00;  hi_a[3] = 16'h0100;  iu_a[3] = 16'h0080;  id_a[3] = 16'hFF80;
        for (int i = 0; i < NP; i++) prev_v[i] = 16'd0;
        pat_up = 1'b1; pat_two = 1'b0; pat_cont = 1'b0; iv = 1; nu = 1; nd = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        for (int i = 0; i < NP; i++)
            chk("R11", int'(value_bus[i*W +: W]), 0, $sformatf("reset lane%0d", i));
        chk("R11", int'(busy), 0, "reset busy");
        chk("R11", int'(done), 0, "reset done");

        // Partial rise with lane2 live, halted mid-way (R8 freeze, leaves lane2 at 70)
        set_pattern(1, 1'b0, 1, 3, 2);
        issue(1);
        for (int t = 0; t <= 2; t++) begin
            if (t > 0) @(negedge clk);
            check_at(t, "");
        end
        halt_check(2);

        // R9 restart while busy
        set_pattern(1, 1'b0, 1, 3, 2);
        issue(1);
        for (int t = 0; t <= 1; t++) begin
            if (t > 0) @(negedge clk);
            check_at(t, "");
        end
        set_pattern(2, 1'b0, 1, 3, 2);
        issue(2);
        for (int t = 0; t <= 4; t++) begin
            if (t > 0) @(negedge clk);
            check_at(t, "R9");
        end
        halt_check(4);

        // R10 reserved code mid-pattern
        set_pattern(3, 1'b0, 2, 3, 2);
        issue(3);
        for (int t = 0; t <= 3; t++) begin
            if (t > 0) @(negedge clk);
            check_at(t, "");
        end
        issue(5);
        for (int t = 4; t <= 12; t++) begin
            if (t > 4) @(negedge clk);
            check_at(t, "R10");
        end
        halt_check(12);

        // Disable lane2: both bounds zero (R7)
        lo_a[2] = 16'd0; hi_a[2] = 16'd0;
        @(negedge clk);

        // Near-exhaustive sweep over patterns, modes, intervals, step counts
        for (int code = 1; code <= 4; code++)
            for (int c = 0; c <= 1; c++)
                for (int ivs = 0; ivs < 3; ivs++)
                    for (int ss = 0; ss < 2; ss++)
                        run_pattern(code, c[0], (ivs == 2) ? 3 : ivs,
                                    (ss == 0) ? 3 : 0, (ss == 0) ? 2 : 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule